// File: doc/BRIEF.md
# Programmable Threshold Offset Port

This block keeps the two thresholds that a dual-clock FIFO's almost-empty and almost-full flags compare against. The almost-empty threshold is called n and the almost-full threshold is called m. Both are loaded through the FIFO's own data inputs and can be read back onto its data outputs. Loading is controlled by a dual-role pin, `en2_or_load`. The level of that pin in the last reset cycle of each clock domain fixes its role until the next reset:
- If it is high, the pin is an active-high second write enable, and the thresholds keep their reset defaults.
- If it is low, the pin is an active-low load control.

In load mode, every load write stores a byte into one of four slots, selected by a rotating pointer. The slots hold the low byte of n, the high part of n, the low byte of m and the high part of m. The high parts are as wide as the address needs beyond eight bits. Load reads on the read clock walk the same four slots with a separate pointer. Each value read back is shown on the data outputs until the next normal FIFO read.

The block also qualifies normal FIFO write and read requests. In load mode it blocks FIFO reads while load is asserted. The memory and the flag comparators sit outside this block. They take `empty_ofs`, `full_ofs`, `fifo_wr_req` and `fifo_rd_req` from it and drive `fifo_q` into it.

Top module: `ofs_load_port`

## Requirements
- R1: A reset sets both n and m to 7, which means 7 in each low-byte slot and 0 in each high slot. It returns both slot pointers to the n-low slot and makes `data_out` follow `fifo_q`.
- R2: The level of `en2_or_load` during the last reset cycle selects the mode: high selects second-write-enable mode and low selects load mode. The mode holds until the next reset.
- R3: In load mode, a write-clock edge with `en2_or_load`=0 and `wr_en1_n`=0 is a load write. Successive load writes fill the slots in this order: n bits 7:0, n high bits, m bits 7:0, m high bits. A high slot takes `wr_data[AW-9:0]`, where AW = log2(DEPTH).
- R4: The fifth load write after the n-low slot wraps back to the n-low slot.
- R5: The write-slot pointer keeps its position when `en2_or_load` returns high. The next load session continues at the following slot.
- R6: A load write needs both controls low. `en2_or_load`=0 with `wr_en1_n`=1, or both controls high, changes neither n nor m and raises no FIFO write.
- R7: In both modes, `fifo_wr_req` is 1 exactly when `wr_en1_n`=0 and `en2_or_load`=1.
- R8: `fifo_rd_req` requires both `rd_en1_n` and `rd_en2_n` to be low. In load mode it also requires `en2_or_load`=1. In second-write-enable mode the pin level does not affect it.
- R9: In load mode, a read-clock edge with `en2_or_load`=0 and both read enables low is a load read. It shows the next slot on `data_out`, using the R3 order, zero-extended to the word width. The value stays there until an edge with `fifo_rd_req`=1 switches `data_out` back to `fifo_q`.
- R10: In second-write-enable mode, no combination of inputs changes n or m.
- R11: n and m change only on a load write or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_en1_n | input | 1 | Active-low primary write enable |
| en2_or_load | input | 1 | Dual-role pin: second write enable or active-low load control |
| wr_data | input | WORD_W | FIFO data input; also carries slot bytes |
| rd_en1_n | input | 1 | Active-low read enable 1 |
| rd_en2_n | input | 1 | Active-low read enable 2 |
| fifo_q | input | WORD_W | Word from the FIFO output register |
| fifo_wr_req | output | 1 | Qualified normal FIFO write request |
| fifo_rd_req | output | 1 | Qualified normal FIFO read request |
| data_out | output | WORD_W | `fifo_q` or the last slot read back |
| empty_ofs | output | AW | Almost-empty threshold n |
| full_ofs | output | AW | Almost-full threshold m |

## Verification
The load path is driven by a vector table that mixes four kinds of write-clock patterns: load writes, idle patterns with one control high, normal FIFO writes interleaved between load sessions, and a fifth load write. This separates a wrong slot order from a pointer that resets between sessions, and both from a missing wrap. Five successive load reads check the readback order, the zero-extension of the high slots and the read-side wrap. A following FIFO read shows that the output switches back to `fifo_q`. Resets with the pin high and then low tell the two modes apart through read gating and through attempts to write the thresholds.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    localparam int LSB_W       = 8;
    localparam int DEFAULT_OFS = 7;

    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    typedef enum logic {
        MODE_WE2  = 1'b0,
        MODE_LOAD = 1'b1
    } pin_mode_e;

    function automatic slot_e slot_next(slot_e s);
        return slot_e'(s + 2'd1);
    endfunction
endpackage

// File: rtl/ofs_mode_capture.sv
module ofs_mode_capture
    import ofs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output pin_mode_e mode
);
    // Follows the pin while reset is held; frozen once reset is released.
    always_ff @(posedge clk) begin
        if (rst) mode <= pin ? MODE_WE2 : MODE_LOAD;
    end
endmodule

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
    import ofs_pkg::*;
#(
    parameter int AW     = 9,
    parameter int WORD_W = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_mode_e     mode,
    input  logic          wen1_n,
    input  logic          pin,
    input  logic [WORD_W-1:0] wr_data,
    output logic [AW-1:0] empty_ofs,
    output logic [AW-1:0] full_ofs,
    output slot_e         wr_slot,
    output logic          ld_wr
);
    localparam int MSB_W = AW - LSB_W;

    logic [LSB_W-1:0] e_lo, f_lo;
    logic [MSB_W-1:0] e_hi, f_hi;
    logic             unused_hi;

    assign unused_hi = ^wr_data;
    assign ld_wr     = (mode == MODE_LOAD) && !pin && !wen1_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            e_lo    <= LSB_W'(DEFAULT_OFS);
            f_lo    <= LSB_W'(DEFAULT_OFS);
            e_hi    <= '0;
            f_hi    <= '0;
            wr_slot <= SLOT_E_LO;
        end else if (ld_wr) begin
            case (wr_slot)
                SLOT_E_LO: e_lo <= wr_data[LSB_W-1:0];
                SLOT_E_HI: e_hi <= wr_data[MSB_W-1:0];
                SLOT_F_LO: f_lo <= wr_data[LSB_W-1:0];
                default:   f_hi <= wr_data[MSB_W-1:0];
            endcase
            wr_slot <= slot_next(wr_slot);
        end
    end

    assign empty_ofs = {e_hi, e_lo};
    assign full_ofs  = {f_hi, f_lo};
endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
    import ofs_pkg::*;
#(
    parameter int AW     = 9,
    parameter int WORD_W = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_mode_e     mode,
    input  logic          pin,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW-1:0] full_ofs,
    input  logic [WORD_W-1:0] fifo_q,
    output logic          fifo_rd_req,
    output logic          ld_rd,
    output logic [WORD_W-1:0] data_out
);
    slot_e             rd_slot;
    logic              sel_ofs;
    logic [WORD_W-1:0] ofs_q;
    logic [WORD_W-1:0] slot_val;
    logic              both_ren;

    assign both_ren    = !ren1_n && !ren2_n;
    assign ld_rd       = (mode == MODE_LOAD) && !pin && both_ren;
    assign fifo_rd_req = both_ren && ((mode == MODE_WE2) || pin);

    always_comb begin
        case (rd_slot)
            SLOT_E_LO: slot_val = WORD_W'(empty_ofs[LSB_W-1:0]);
            SLOT_E_HI: slot_val = WORD_W'(empty_ofs[AW-1:LSB_W]);
            SLOT_F_LO: slot_val = WORD_W'(full_ofs[LSB_W-1:0]);
            default:   slot_val = WORD_W'(full_ofs[AW-1:LSB_W]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_slot <= SLOT_E_LO;
            ofs_q   <= '0;
            sel_ofs <= 1'b0;
        end else if (ld_rd) begin
            ofs_q   <= slot_val;
            sel_ofs <= 1'b1;
            rd_slot <= slot_next(rd_slot);
        end else if (fifo_rd_req) begin
            sel_ofs <= 1'b0;
        end
    end

    assign data_out = sel_ofs ? ofs_q : fifo_q;
endmodule

// File: rtl/ofs_load_port.sv
module ofs_load_port
    import ofs_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 9,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en1_n,
    input  logic              en2_or_load,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic [WORD_W-1:0] fifo_q,
    output logic              fifo_wr_req,
    output logic              fifo_rd_req,
    output logic [WORD_W-1:0] data_out,
    output logic [AW-1:0]     empty_ofs,
    output logic [AW-1:0]     full_ofs
);
    pin_mode_e wr_mode, rd_mode;
    slot_e     wr_slot;
    logic      ld_wr, ld_rd;

    ofs_mode_capture i_wr_mode (.clk(wr_clk), .rst(rst), .pin(en2_or_load), .mode(wr_mode));
    ofs_mode_capture i_rd_mode (.clk(rd_clk), .rst(rst), .pin(en2_or_load), .mode(rd_mode));

    assign fifo_wr_req = !wr_en1_n && en2_or_load;

    ofs_wr_side #(.AW(AW), .WORD_W(WORD_W)) i_wr_side (
        .clk(wr_clk), .rst(rst), .mode(wr_mode), .wen1_n(wr_en1_n),
        .pin(en2_or_load), .wr_data(wr_data), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .wr_slot(wr_slot), .ld_wr(ld_wr)
    );

    ofs_rd_side #(.AW(AW), .WORD_W(WORD_W)) i_rd_side (
        .clk(rd_clk), .rst(rst), .mode(rd_mode), .pin(en2_or_load),
        .ren1_n(rd_en1_n), .ren2_n(rd_en2_n), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .fifo_q(fifo_q), .fifo_rd_req(fifo_rd_req),
        .ld_rd(ld_rd), .data_out(data_out)
    );
endmodule

// File: rtl/ofs_load_port_chk.sv
module ofs_load_port_chk
    import ofs_pkg::*;
#(
    parameter int AW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic          en2_or_load,
    input logic          fifo_rd_req,
    input logic          ld_wr,
    input logic          ld_rd,
    input pin_mode_e     wr_mode,
    input pin_mode_e     rd_mode,
    input slot_e         wr_slot,
    input logic [AW-1:0] empty_ofs,
    input logic [AW-1:0] full_ofs
);
    AST_RESET_DEFAULTS: assert property (@(posedge wr_clk)
        rst |=> (empty_ofs == AW'(DEFAULT_OFS)) && (full_ofs == AW'(DEFAULT_OFS))); // R1

    AST_OFS_HOLD: assert property (@(posedge wr_clk) disable iff (rst)
        !ld_wr |=> $stable(empty_ofs) && $stable(full_ofs)); // R11

    AST_WE2_NO_PROG: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_mode == MODE_WE2) |=> $stable(empty_ofs) && $stable(full_ofs)); // R10

    AST_SLOT_WRAP: assert property (@(posedge wr_clk) disable iff (rst)
        (ld_wr && wr_slot == SLOT_F_HI) |=> (wr_slot == SLOT_E_LO)); // R4

    AST_LOAD_BLOCKS_READ: assert property (@(posedge rd_clk) disable iff (rst)
        (rd_mode == MODE_LOAD && !en2_or_load) |-> !fifo_rd_req); // R8

    AST_LOAD_READ_EXCL: assert property (@(posedge rd_clk) disable iff (rst)
        ld_rd |-> !fifo_rd_req); // R9
endmodule

bind ofs_load_port ofs_load_port_chk #(.AW(AW)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .en2_or_load(en2_or_load),
    .fifo_rd_req(fifo_rd_req), .ld_wr(ld_wr), .ld_rd(ld_rd),
    .wr_mode(wr_mode), .rd_mode(rd_mode), .wr_slot(wr_slot),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/test_ofs_load_port.sv
`timescale 1ns/1ps
module test_ofs_load_port;
    localparam int DEPTH  = 512;
    localparam int WORD_W = 9;
    localparam int AW     = 9;
    localparam logic [WORD_W-1:0] FQ = 9'h155;

    logic wr_clk = 0, rd_clk = 0, rst = 1;
    logic wr_en1_n = 1, en2_or_load = 0, rd_en1_n = 1, rd_en2_n = 1;
    logic [WORD_W-1:0] wr_data = '0;
    logic [WORD_W-1:0] fifo_q = FQ;
    logic fifo_wr_req, fifo_rd_req;
    logic [WORD_W-1:0] data_out;
    logic [AW-1:0] empty_ofs, full_ofs;

    int compared = 0, mismatched = 0;
    bit done = 0;

    always #10 wr_clk = ~wr_clk;
    initial begin #5; forever #10 rd_clk = ~rd_clk; end

    ofs_load_port #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_ofs_load_port (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en1_n(wr_en1_n),
        .en2_or_load(en2_or_load), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .fifo_q(fifo_q), .fifo_wr_req(fifo_wr_req),
        .fifo_rd_req(fifo_rd_req), .data_out(data_out),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    typedef struct packed {
        logic       wen1_n;
        logic       pin;
        logic [8:0] d;
        logic [8:0] exp_n;
        logic [8:0] exp_m;
        logic       exp_wr;
        logic [3:0] req;
    } vec_t;

    // Load-mode walk: R3 order, R6 no-ops, R7 FIFO writes between sessions (R5), R4 wrap.
    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 9'h021, 9'h021, 9'h007, 1'b0, 4'd3},
        '{1'b1, 1'b0, 9'h0FF, 9'h021, 9'h007, 1'b0, 4'd6},
        '{1'b0, 1'b1, 9'h0AA, 9'h021, 9'h007, 1'b1, 4'd7},
        '{1'b0, 1'b0, 9'h001, 9'h121, 9'h007, 1'b0, 4'd5},
        '{1'b0, 1'b0, 9'h035, 9'h121, 9'h035, 1'b0, 4'd3},
        '{1'b1, 1'b1, 9'h000, 9'h121, 9'h035, 1'b0, 4'd6},
        '{1'b0, 1'b0, 9'h003, 9'h121, 9'h135, 1'b0, 4'd5},
        '{1'b0, 1'b0, 9'h044, 9'h144, 9'h135, 1'b0, 4'd4}
    };

    task automatic check(input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin_lvl);
        rst = 1; en2_or_load = pin_lvl; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk); rst = 0;
        @(posedge wr_clk); @(posedge rd_clk); #1;
    endtask

    task automatic wr_step(input logic w, input logic p, input logic [8:0] d, input logic exp_wr, input string tag);
        @(negedge wr_clk);
        wr_en1_n = w; en2_or_load = p; wr_data = d;
        #2 check({tag, " fifo_wr_req"}, int'(fifo_wr_req), int'(exp_wr));
        @(posedge wr_clk); #1;
        wr_en1_n = 1;
    endtask

    task automatic rd_step(input logic r1, input logic r2, input logic p, input logic exp_rd, input string tag);
        @(negedge rd_clk);
        rd_en1_n = r1; rd_en2_n = r2; en2_or_load = p;
        #2 check({tag, " fifo_rd_req"}, int'(fifo_rd_req), int'(exp_rd));
        @(posedge rd_clk); #1;
        rd_en1_n = 1; rd_en2_n = 1;
    endtask

    initial begin
        do_reset(1'b0);                       // load mode
        check("R1 reset n", int'(empty_ofs), 7);
        check("R1 reset m", int'(full_ofs), 7);
        check("R1 reset data_out", int'(data_out), int'(FQ));

        foreach (VEC[i]) begin
            wr_step(VEC[i].wen1_n, VEC[i].pin, VEC[i].d, VEC[i].exp_wr,
                    $sformatf("R%0d vec%0d", VEC[i].req, i));
            check($sformatf("R%0d vec%0d n", VEC[i].req, i), int'(empty_ofs), int'(VEC[i].exp_n));
            check($sformatf("R%0d vec%0d m", VEC[i].req, i), int'(full_ofs), int'(VEC[i].exp_m));
        end

        // R9 readback walk with wrap; R8 load blocks FIFO reads
        begin
            automatic logic [8:0] exp_rb [5] = '{9'h044, 9'h001, 9'h035, 9'h001, 9'h044};
            for (int k = 0; k < 5; k++) begin
                rd_step(1'b0, 1'b0, 1'b0, 1'b0, "R8 load read");
                check($sformatf("R9 readback %0d", k), int'(data_out), int'(exp_rb[k]));
            end
        end
        rd_step(1'b0, 1'b1, 1'b1, 1'b0, "R8 one enable");
        check("R9 held after non-read", int'(data_out), 9'h044);
        rd_step(1'b0, 1'b0, 1'b1, 1'b1, "R8 fifo read");
        check("R9 back to fifo_q", int'(data_out), int'(FQ));

        // R1 / R2 / R10: second-write-enable mode
        do_reset(1'b1);
        check("R1 n restored", int'(empty_ofs), 7);
        check("R1 m restored", int'(full_ofs), 7);
        wr_step(1'b0, 1'b0, 9'h0AA, 1'b0, "R10 we2 pin low");
        check("R10 n unchanged", int'(empty_ofs), 7);
        check("R10 m unchanged", int'(full_ofs), 7);
        wr_step(1'b0, 1'b1, 9'h0BB, 1'b1, "R7 we2 write");
        check("R10 n after write", int'(empty_ofs), 7);
        rd_step(1'b0, 1'b0, 1'b0, 1'b1, "R2 we2 read pin low");
        check("R2 data_out fifo", int'(data_out), int'(FQ));

        // R2: back to load mode; read pointer restarts at first slot (R1)
        do_reset(1'b0);
        rd_step(1'b0, 1'b0, 1'b0, 1'b0, "R2 load read");
        check("R1 read pointer reset", int'(data_out), 7);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule